// File: doc/BRIEF.md
# Dual-Port Unified Address Translation Buffer

This block is a fully associative translation buffer used by both the data side and the instruction side of a processor core. Every cycle it can translate two virtual addresses into 40-bit physical addresses, one on each lookup port. Port 0 carries only data (load/store) requests. Port 1 is shared: a data request always wins it. A refill request from the small fetch-side buffer, sent after that buffer misses, gets port 1 only in a cycle where no data request wants it. Otherwise the refill request is turned away, a stall flag tells the fetch side, and the fetch side holds the request and tries again.

Each entry maps one page. The page size is a power of four between 4 KB and 16 MB, given as a 3-bit code. Virtual address bits inside the page are left out of the tag compare and are copied straight into the physical address. Each entry also carries one bit that picks static or dynamic branch prediction for the page. On a hit, that bit and the size code come back with the translation. Entries are loaded through an insert port and replaced in round-robin order. Page-table walking and permission checks are done elsewhere.

Top module: `dual_tlb`

## Requirements
- R1: Reset clears every entry to invalid and drives rsp0_valid, rsp1_valid and if_stall low. A lookup made right after reset reports a miss.
- R2: A request sampled on a clock edge produces its response on the next edge. Ports 0 and 1 translate independently in the same cycle.
- R3: For an entry with size code k (0 to 6, meaning 4 KB × 4^k), virtual address bits below 12+2k are left out of the match. The same bits are copied into the physical address unchanged.
- R4: On a hit, physical address bits 39 down to 12+2k come from the entry's stored physical tag.
- R5: On a hit, the response returns the entry's 3-bit size code and its branch-mode bit (1 = dynamic, 0 = static).
- R6: A lookup that matches no valid entry sets that port's miss flag. In that case the physical address, size code and branch-mode bit are all zero.
- R7: Port 1 serves d1 whenever d1_valid is high, with rsp1_inst = 0. When d1_valid is low and if_valid is high, it serves the fetch request, with rsp1_inst = 1.
- R8: if_stall is high in the cycle after a cycle in which if_valid and d1_valid were both high. Otherwise it is low.
- R9: Inserts fill entry slots 0, 1, 2, … in turn and wrap to slot 0 after the last slot. Once N further inserts have been made, the oldest entry is replaced and its address misses.
- R10: An insert is seen by lookups from the next cycle on. A lookup in the same cycle as the insert sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d0_valid | input | 1 | Data request on port 0 |
| d0_vaddr | input | VA_W | Virtual address for port 0 |
| d1_valid | input | 1 | Data request on port 1 |
| d1_vaddr | input | VA_W | Virtual address for port 1 data request |
| if_valid | input | 1 | Fetch-side refill request |
| if_vaddr | input | VA_W | Virtual address of refill request |
| ins_valid | input | 1 | Write an entry |
| ins_vtag | input | VA_W-12 | Virtual page tag (address bits above 11) |
| ins_ptag | input | PA_W-12 | Physical page tag (address bits above 11) |
| ins_size | input | 3 | Page size code k, 0..6 |
| ins_dyn | input | 1 | Branch-mode bit of the page |
| rsp0_valid | output | 1 | Port 0 response present |
| rsp0_miss | output | 1 | Port 0 found no entry |
| rsp0_paddr | output | PA_W | Port 0 physical address |
| rsp0_size | output | 3 | Port 0 page size code |
| rsp0_dyn | output | 1 | Port 0 branch-mode bit |
| rsp1_valid | output | 1 | Port 1 response present |
| rsp1_inst | output | 1 | Port 1 response belongs to the fetch request |
| rsp1_miss | output | 1 | Port 1 found no entry |
| rsp1_paddr | output | PA_W | Port 1 physical address |
| rsp1_size | output | 3 | Port 1 page size code |
| rsp1_dyn | output | 1 | Port 1 branch-mode bit |
| if_stall | output | 1 | Previous fetch request was not served |

## Verification
The assertions assume two things about the inputs. Software never leaves two valid entries that match the same address, and the insert size code never exceeds 6. The stimulus meets both conditions. Every inserted page sits in its own 16 MB-aligned region, taken from a counter that is never reused, so no two pages overlap whatever their sizes. Addresses meant to miss are drawn from a high region that is never inserted, and size codes are drawn only from 0 to 6.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int PG_SHIFT      = 12;
  localparam int SIZE_W        = 3;
  localparam int MAX_SIZE_CODE = 6;

  typedef enum logic {
    OWN_DATA = 1'b0,
    OWN_INST = 1'b1
  } p1_owner_e;
endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int N    = 96,
  parameter int VT_W = 36,
  parameter int PT_W = 28,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [VT_W-1:0]   ins_vtag,
  input  logic [PT_W-1:0]   ins_ptag,
  input  logic [SIZE_W-1:0] ins_size,
  input  logic              ins_dyn,
  output logic [N-1:0]      e_valid,
  output logic [VT_W-1:0]   e_vtag [N],
  output logic [PT_W-1:0]   e_ptag [N],
  output logic [SIZE_W-1:0] e_size [N],
  output logic [N-1:0]      e_dyn
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] wr_ptr;

  // Round-robin replacement pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (ins_valid) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  // Valid bits need reset; payload does not
  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
    end else if (ins_valid) begin
      e_valid[wr_ptr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      e_vtag[wr_ptr] <= ins_vtag;
      e_ptag[wr_ptr] <= ins_ptag;
      e_size[wr_ptr] <= ins_size;
      e_dyn[wr_ptr]  <= ins_dyn;
    end
  end

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (ins_size <= SIZE_W'(MAX_SIZE_CODE))); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && wr_ptr == LAST) |=> (wr_ptr == '0)); // R9
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> e_valid[$past(wr_ptr)]); // R10
endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int N    = 96,
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  localparam int VT_W = VA_W - PG_SHIFT,
  localparam int PT_W = PA_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [N-1:0]      e_valid,
  input  logic [VT_W-1:0]   e_vtag [N],
  input  logic [PT_W-1:0]   e_ptag [N],
  input  logic [SIZE_W-1:0] e_size [N],
  input  logic [N-1:0]      e_dyn,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [SIZE_W-1:0] rsp_size,
  output logic              rsp_dyn
);
  logic [N-1:0]      hit;
  logic [PT_W-1:0]   ptag_m [N];
  logic [SIZE_W-1:0] size_m [N];
  logic [VT_W-1:0]   req_vt;
  logic [PT_W-1:0]   req_pt;

  assign req_vt = req_vaddr[VA_W-1:PG_SHIFT];
  assign req_pt = req_vaddr[PA_W-1:PG_SHIFT];

  // Per-entry size-masked compare and physical tag merge
  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    logic [VT_W-1:0] vkeep;
    logic [PT_W-1:0] pkeep;
    assign vkeep = {VT_W{1'b1}} << {e_size[gi], 1'b0};
    assign pkeep = {PT_W{1'b1}} << {e_size[gi], 1'b0};
    assign hit[gi] = e_valid[gi] && (((e_vtag[gi] ^ req_vt) & vkeep) == '0);
    assign ptag_m[gi] = hit[gi] ? ((e_ptag[gi] & pkeep) | (req_pt & ~pkeep)) : '0;
    assign size_m[gi] = hit[gi] ? e_size[gi] : '0;
  end

  // AND-OR selection: at most one hit by software contract
  logic [PT_W-1:0]   ptag_sel;
  logic [SIZE_W-1:0] size_sel;
  logic              dyn_sel;
  always_comb begin
    ptag_sel = '0;
    size_sel = '0;
    dyn_sel  = 1'b0;
    for (int i = 0; i < N; i++) begin
      ptag_sel = ptag_sel | ptag_m[i];
      size_sel = size_sel | size_m[i];
      dyn_sel  = dyn_sel | (hit[i] & e_dyn[i]);
    end
  end

  logic any_hit;
  assign any_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
      rsp_size  <= '0;
      rsp_dyn   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_miss  <= req_valid && !any_hit;
      rsp_paddr <= (req_valid && any_hit) ? {ptag_sel, req_vaddr[PG_SHIFT-1:0]} : '0;
      rsp_size  <= req_valid ? size_sel : '0;
      rsp_dyn   <= req_valid && dyn_sel;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($countones(hit) <= 1)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == '0 && rsp_size == '0 && !rsp_dyn)); // R6
endmodule

// File: rtl/tlbx_arb.sv
module tlbx_arb
  import tlbx_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic            d1_valid,
  input  logic [VA_W-1:0] d1_vaddr,
  input  logic            if_valid,
  input  logic [VA_W-1:0] if_vaddr,
  output logic            p1_valid,
  output logic [VA_W-1:0] p1_vaddr,
  output logic            p1_inst,
  output logic            if_blocked
);
  p1_owner_e owner;

  always_comb begin
    owner      = (d1_valid || !if_valid) ? OWN_DATA : OWN_INST;
    p1_valid   = d1_valid || if_valid;
    p1_vaddr   = (owner == OWN_INST) ? if_vaddr : d1_vaddr;
    p1_inst    = (owner == OWN_INST);
    if_blocked = if_valid && d1_valid;
  end
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
  import tlbx_pkg::*;
#(
  parameter int N    = 96,
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  localparam int VT_W = VA_W - PG_SHIFT,
  localparam int PT_W = PA_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d0_valid,
  input  logic [VA_W-1:0]   d0_vaddr,
  input  logic              d1_valid,
  input  logic [VA_W-1:0]   d1_vaddr,
  input  logic              if_valid,
  input  logic [VA_W-1:0]   if_vaddr,
  input  logic              ins_valid,
  input  logic [VT_W-1:0]   ins_vtag,
  input  logic [PT_W-1:0]   ins_ptag,
  input  logic [SIZE_W-1:0] ins_size,
  input  logic              ins_dyn,
  output logic              rsp0_valid,
  output logic              rsp0_miss,
  output logic [PA_W-1:0]   rsp0_paddr,
  output logic [SIZE_W-1:0] rsp0_size,
  output logic              rsp0_dyn,
  output logic              rsp1_valid,
  output logic              rsp1_inst,
  output logic              rsp1_miss,
  output logic [PA_W-1:0]   rsp1_paddr,
  output logic [SIZE_W-1:0] rsp1_size,
  output logic              rsp1_dyn,
  output logic              if_stall
);
  logic [N-1:0]      e_valid;
  logic [VT_W-1:0]   e_vtag [N];
  logic [PT_W-1:0]   e_ptag [N];
  logic [SIZE_W-1:0] e_size [N];
  logic [N-1:0]      e_dyn;

  logic            p1_valid;
  logic [VA_W-1:0] p1_vaddr;
  logic            p1_inst;
  logic            if_blocked;

  tlbx_store #(.N(N), .VT_W(VT_W), .PT_W(PT_W)) u_store (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_vtag(ins_vtag), .ins_ptag(ins_ptag),
    .ins_size(ins_size), .ins_dyn(ins_dyn),
    .e_valid(e_valid), .e_vtag(e_vtag), .e_ptag(e_ptag),
    .e_size(e_size), .e_dyn(e_dyn)
  );

  tlbx_arb #(.VA_W(VA_W)) u_arb (
    .d1_valid(d1_valid), .d1_vaddr(d1_vaddr),
    .if_valid(if_valid), .if_vaddr(if_vaddr),
    .p1_valid(p1_valid), .p1_vaddr(p1_vaddr),
    .p1_inst(p1_inst), .if_blocked(if_blocked)
  );

  tlbx_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_look0 (
    .clk(clk), .rst(rst),
    .req_valid(d0_valid), .req_vaddr(d0_vaddr),
    .e_valid(e_valid), .e_vtag(e_vtag), .e_ptag(e_ptag),
    .e_size(e_size), .e_dyn(e_dyn),
    .rsp_valid(rsp0_valid), .rsp_miss(rsp0_miss), .rsp_paddr(rsp0_paddr),
    .rsp_size(rsp0_size), .rsp_dyn(rsp0_dyn)
  );

  tlbx_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_look1 (
    .clk(clk), .rst(rst),
    .req_valid(p1_valid), .req_vaddr(p1_vaddr),
    .e_valid(e_valid), .e_vtag(e_vtag), .e_ptag(e_ptag),
    .e_size(e_size), .e_dyn(e_dyn),
    .rsp_valid(rsp1_valid), .rsp_miss(rsp1_miss), .rsp_paddr(rsp1_paddr),
    .rsp_size(rsp1_size), .rsp_dyn(rsp1_dyn)
  );

  // Owner and stall flags aligned with the lookup response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp1_inst <= 1'b0;
      if_stall  <= 1'b0;
    end else begin
      rsp1_inst <= p1_valid && p1_inst;
      if_stall  <= if_blocked;
    end
  end

  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
    d1_valid |=> (rsp1_valid && !rsp1_inst)); // R7
  AST_INST_SERVED: assert property (@(posedge clk) disable iff (rst)
    (if_valid && !d1_valid) |=> (rsp1_valid && rsp1_inst && !if_stall)); // R7
  AST_STALL_ON_CLASH: assert property (@(posedge clk) disable iff (rst)
    (if_valid && d1_valid) |=> if_stall); // R8
endmodule

// File: tb/tb_dual_tlb.sv
module tb_dual_tlb;
  localparam int N = 96;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic d0_v, d1_v, if_v, ins_v, ins_dy;
  logic [47:0] d0_va, d1_va, if_va, ins_va;
  logic [39:0] ins_pa;
  logic [2:0]  ins_sz;

  logic        rsp0_valid, rsp0_miss, rsp0_dyn;
  logic [39:0] rsp0_paddr;
  logic [2:0]  rsp0_size;
  logic        rsp1_valid, rsp1_inst, rsp1_miss, rsp1_dyn, if_stall;
  logic [39:0] rsp1_paddr;
  logic [2:0]  rsp1_size;

  dual_tlb dut (
    .clk(clk), .rst(rst),
    .d0_valid(d0_v), .d0_vaddr(d0_va),
    .d1_valid(d1_v), .d1_vaddr(d1_va),
    .if_valid(if_v), .if_vaddr(if_va),
    .ins_valid(ins_v), .ins_vtag(ins_va[47:12]), .ins_ptag(ins_pa[39:12]),
    .ins_size(ins_sz), .ins_dyn(ins_dy),
    .rsp0_valid(rsp0_valid), .rsp0_miss(rsp0_miss), .rsp0_paddr(rsp0_paddr),
    .rsp0_size(rsp0_size), .rsp0_dyn(rsp0_dyn),
    .rsp1_valid(rsp1_valid), .rsp1_inst(rsp1_inst), .rsp1_miss(rsp1_miss),
    .rsp1_paddr(rsp1_paddr), .rsp1_size(rsp1_size), .rsp1_dyn(rsp1_dyn),
    .if_stall(if_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model of the entry array
  bit [47:0] m_va [N];
  bit [39:0] m_pa [N];
  int        m_sz [N];
  bit        m_dy [N];
  bit        m_v  [N];
  int        m_ptr = 0;
  int        region = 'h100;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic void ref_lookup(input bit [47:0] va, output bit hit,
                                     output bit [39:0] pa, output bit [2:0] sz, output bit dy);
    hit = 0; pa = '0; sz = '0; dy = 0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i]) begin
        int sh = 12 + 2 * m_sz[i];
        if ((va >> sh) == (m_va[i] >> sh)) begin
          hit = 1;
          pa  = ((m_pa[i] >> sh) << sh) | (40'(va) & ((40'd1 << sh) - 40'd1));
          sz  = 3'(m_sz[i]);
          dy  = m_dy[i];
        end
      end
    end
  endfunction

  task automatic idle();
    d0_v = 0; d1_v = 0; if_v = 0; ins_v = 0;
    d0_va = '0; d1_va = '0; if_va = '0; ins_va = '0; ins_pa = '0; ins_sz = '0; ins_dy = 0;
  endtask

  // Prepare a new, non-overlapping entry on the insert port
  task automatic set_insert(input int sz);
    ins_v  = 1;
    ins_va = {24'(region), 12'($urandom), 12'h0};
    ins_pa = {$urandom, 8'($urandom)};
    ins_sz = 3'(sz);
    ins_dy = 1'($urandom);
    region++;
  endtask

  function automatic bit [47:0] addr_in(input int idx);
    int sh = 12 + 2 * m_sz[idx];
    bit [47:0] r = {$urandom, 16'($urandom)};
    return ((m_va[idx] >> sh) << sh) | (r & ((48'd1 << sh) - 48'd1));
  endfunction

  function automatic bit [47:0] addr_miss();
    return {8'hFF, 8'($urandom), $urandom};
  endfunction

  // Apply current inputs for one cycle and check the registered responses
  task automatic step(input string tag);
    bit h0, h1, y0, y1, e_v1, e_inst, e_stall;
    bit [39:0] p0, p1;
    bit [2:0] s0, s1;
    bit [47:0] va1;
    bit sd0 = d0_v;
    ref_lookup(d0_va, h0, p0, s0, y0);
    e_v1    = d1_v || if_v;
    e_inst  = if_v && !d1_v;
    e_stall = if_v && d1_v;
    va1     = d1_v ? d1_va : if_va;
    ref_lookup(va1, h1, p1, s1, y1);
    if (ins_v) begin
      m_va[m_ptr] = ins_va; m_pa[m_ptr] = ins_pa;
      m_sz[m_ptr] = int'(ins_sz); m_dy[m_ptr] = ins_dy; m_v[m_ptr] = 1;
      m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    end
    @(posedge clk); #1;
    chk(rsp0_valid == sd0, {tag, " R2 port0 valid"}, 64'(rsp0_valid), 64'(sd0));
    if (sd0) begin
      chk(rsp0_miss == !h0, {tag, " R6 port0 miss"}, 64'(rsp0_miss), 64'(!h0));
      chk(rsp0_paddr == p0, {tag, " R3 R4 port0 paddr"}, 64'(rsp0_paddr), 64'(p0));
      chk(rsp0_size == s0 && rsp0_dyn == y0, {tag, " R5 port0 size/mode"},
          64'({rsp0_size, rsp0_dyn}), 64'({s0, y0}));
    end
    chk(rsp1_valid == e_v1, {tag, " R2 port1 valid"}, 64'(rsp1_valid), 64'(e_v1));
    chk(if_stall == e_stall, {tag, " R8 stall"}, 64'(if_stall), 64'(e_stall));
    if (e_v1) begin
      chk(rsp1_inst == e_inst, {tag, " R7 port1 owner"}, 64'(rsp1_inst), 64'(e_inst));
      chk(rsp1_miss == !h1, {tag, " R6 port1 miss"}, 64'(rsp1_miss), 64'(!h1));
      chk(rsp1_paddr == p1, {tag, " R3 R4 port1 paddr"}, 64'(rsp1_paddr), 64'(p1));
      chk(rsp1_size == s1 && rsp1_dyn == y1, {tag, " R5 port1 size/mode"},
          64'({rsp1_size, rsp1_dyn}), 64'({s1, y1}));
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    bit [47:0] base;
    int first_slot;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_v[i] = 0;
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp0_valid && !rsp1_valid && !if_stall, "R1 outputs in reset",
        64'({rsp0_valid, rsp1_valid, if_stall}), 64'(0));
    @(negedge clk);
    rst = 0;

    // R1: empty after reset
    d0_v = 1; d0_va = addr_miss(); d1_v = 1; d1_va = {24'h000100, 24'h0};
    step("R1 lookup after reset");
    chk(rsp0_miss && rsp1_miss, "R1 both miss", 64'({rsp0_miss, rsp1_miss}), 64'(3));
    idle();

    // R3: 16 KB page boundaries
    base = {24'h000050, 24'h123000};
    ins_v = 1; ins_va = base; ins_pa = 40'hAB_CDEF_0000; ins_sz = 3'd1; ins_dy = 1;
    step("R10 insert");
    idle();
    d0_v = 1; d0_va = base | 48'h3ABC;
    d1_v = 1; d1_va = base | 48'h4000;
    step("R3 size mask");
    chk(!rsp0_miss && rsp0_paddr == 40'hAB_CDEF_3ABC, "R3 in-page hit",
        64'(rsp0_paddr), 64'h00AB_CDEF_3ABC);
    chk(rsp1_miss, "R3 next-page miss", 64'(rsp1_miss), 64'(1));
    idle();

    // R10: same-cycle insert is not seen, next cycle is
    set_insert(0);
    d0_v = 1; d0_va = ins_va | 48'h5A5;
    step("R10 same cycle");
    chk(rsp0_miss, "R10 same-cycle lookup misses", 64'(rsp0_miss), 64'(1));
    ins_v = 0;
    step("R10 next cycle");
    chk(!rsp0_miss, "R10 next-cycle lookup hits", 64'(rsp0_miss), 64'(0));
    idle();

    // R7 / R8 directed arbitration
    if_v = 1; if_va = base | 48'h10; d1_v = 1; d1_va = addr_miss();
    step("R8 clash");
    chk(if_stall && !rsp1_inst, "R8 clash stalls fetch", 64'({if_stall, rsp1_inst}), 64'(2));
    d1_v = 0;
    step("R7 fetch served");
    chk(rsp1_inst && !if_stall && !rsp1_miss, "R7 fetch uses port1",
        64'({rsp1_inst, if_stall, rsp1_miss}), 64'(4));
    idle();

    // Random mix
    for (int c = 0; c < 1500; c++) begin
      int pick;
      idle();
      if (($urandom % 6) == 0) set_insert(int'($urandom % 7));
      d0_v = 1'($urandom); d1_v = 1'($urandom); if_v = 1'($urandom);
      pick = int'($urandom % N);
      d0_va = (m_v[pick] && $urandom % 4 != 0) ? addr_in(pick) : addr_miss();
      pick = int'($urandom % N);
      d1_va = (m_v[pick] && $urandom % 4 != 0) ? addr_in(pick) : addr_miss();
      pick = int'($urandom % N);
      if_va = (m_v[pick] && $urandom % 4 != 0) ? addr_in(pick) : addr_miss();
      step("random");
    end
    idle();

    // R9: N further inserts evict the oldest
    first_slot = m_ptr;
    set_insert(2);
    step("R9 oldest insert");
    base = m_va[first_slot];
    for (int k = 0; k < N; k++) begin
      set_insert(int'($urandom % 7));
      step("R9 fill");
    end
    idle();
    d0_v = 1; d0_va = base;
    d1_v = 1; d1_va = m_va[(first_slot + 1) % N];
    step("R9 wrap");
    chk(rsp0_miss, "R9 oldest entry replaced", 64'(rsp0_miss), 64'(1));
    chk(!rsp1_miss, "R9 newer entry present", 64'(rsp1_miss), 64'(0));
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule